// File: doc/BRIEF.md
# Sequencer Arithmetic/Logic Unit with Persistent Carry

This block is the arithmetic and logic stage of a small command-macro sequencer. Each cycle it receives two 32-bit operands and a 4-bit operation code, and it returns a 32-bit result combinationally. There are four arithmetic operations: add, add with carry-in, subtract, and subtract with borrow. There are five bitwise operations. One carry bit is held in a register across instructions, so a wide value can be added or subtracted as a chain of 32-bit words.

For subtraction the carry bit means "no borrow happened": it is 1 when the minuend was not smaller than what was taken from it. The flag changes only on a clock edge where the flag-write enable is high and the operation is arithmetic. The sequencer pulses a synchronous clear when a new macro starts, and this forces the flag to zero. A code outside the defined set gives a zero result and raises an illegal-operation indication.

Top module: `macro_alu`

## Requirements
- R1: Code 0 (add): `res_o` equals the low 32 bits of A+B. On the next edge with the enable high, the carry becomes 1 exactly when the true sum exceeds 0xFFFFFFFF.
- R2: Code 1 (add with carry): `res_o` equals the low 32 bits of A+B+carry. The new carry is 1 exactly when that full sum exceeds 0xFFFFFFFF.
- R3: Code 2 (subtract): `res_o` equals A−B modulo 2^32. The new carry is 1 exactly when A ≥ B as unsigned values.
- R4: Code 3 (subtract with borrow): `res_o` equals A−B when the carry is 1 and A−B−1 when the carry is 0. The new carry is 1 exactly when A ≥ B+(1−carry) as unsigned values.
- R5: Codes 8 to 12 give, in order: A XOR B, A OR B, A AND B, A AND NOT B, and NOT (A AND B).
- R6: A bitwise operation never changes the carry, even with the enable high.
- R7: With `flag_en_i` low, no operation changes the carry.
- R8: `clr_i` high at an edge forces the carry to 0, and it takes priority over a flag update in the same cycle.
- R9: Codes 4 to 7 and 13 to 15 are illegal. They give `res_o` = 0 and `illegal_o` = 1 and leave the carry unchanged. `illegal_o` is 0 for every legal code.
- R10: After synchronous reset `carry_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Macro-start clear of the carry flag |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| flag_en_i | input | 1 | Allows an arithmetic operation to write the carry |
| res_o | output | 32 | Combinational result |
| carry_o | output | 1 | Current carry flag |
| illegal_o | output | 1 | Operation code is not defined |

## Verification
The carry bit is the only internal state. If it is wrong, `carry_o` shows the error one edge after the faulty update. The next add-with-carry or subtract-with-borrow also shows it on `res_o` in the same cycle, as an off-by-one. A wrong clear priority, or an update from a bitwise or illegal code, shows up one cycle later as a carry that differs from the reference model. Random sequences that chain carry-dependent operations, with the enable and the clear toggled, expose these errors within a few instructions.

// File: rtl/macro_alu_pkg.sv
package macro_alu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBB  = 4'd3,
        OP_XOR  = 4'd8,
        OP_OR   = 4'd9,
        OP_AND  = 4'd10,
        OP_ANDN = 4'd11,
        OP_NAND = 4'd12
    } alu_op_e;

    typedef enum logic [1:0] {
        CLS_ARITH,
        CLS_LOGIC,
        CLS_BAD
    } op_class_e;

    function automatic op_class_e classify(input logic [OP_W-1:0] code);
        op_class_e c;
        if (code <= 4'd3)
            c = CLS_ARITH;
        else if (code >= 4'd8 && code <= 4'd12)
            c = CLS_LOGIC;
        else
            c = CLS_BAD;
        return c;
    endfunction

endpackage

// File: rtl/macro_alu_arith.sv
module macro_alu_arith
    import macro_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic            cin,
    output logic [W-1:0]    res,
    output logic            cout
);
    localparam int EW = W + 1;

    logic [EW-1:0] ax, bx, cx, bw, sum, dif;

    always_comb begin
        ax  = {1'b0, a};
        bx  = {1'b0, b};
        cx  = {{W{1'b0}}, cin};
        bw  = {{W{1'b0}}, ~cin};
        sum = ax + bx + ((op == OP_ADC) ? cx : '0);
        dif = ax - bx - ((op == OP_SBB) ? bw : '0);
        res  = '0;
        cout = cin;
        case (op)
            OP_ADD, OP_ADC: begin
                res  = sum[W-1:0];
                cout = sum[W];
            end
            OP_SUB, OP_SBB: begin
                res  = dif[W-1:0];
                cout = ~dif[W];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/macro_alu_logic.sv
module macro_alu_logic
    import macro_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    output logic [W-1:0]    res
);
    always_comb begin
        case (op)
            OP_XOR:  res = a ^ b;
            OP_OR:   res = a | b;
            OP_AND:  res = a & b;
            OP_ANDN: res = a & ~b;
            OP_NAND: res = ~(a & b);
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/macro_alu_flag.sv
module macro_alu_flag (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic upd,
    input  logic nxt,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            q <= 1'b0;
        else if (upd)
            q <= nxt;
    end

    p_clear_wins_r8: assert property (@(posedge clk) disable iff (rst)
        clr |=> !q);

    p_hold_no_update_r7: assert property (@(posedge clk) disable iff (rst)
        (!clr && !upd) |=> $stable(q));

    p_reset_zero_r10: assert property (@(posedge clk)
        rst |=> !q);
endmodule

// File: rtl/macro_alu.sv
module macro_alu
    import macro_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr_i,
    input  logic [OP_W-1:0] op_i,
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    input  logic            flag_en_i,
    output logic [W-1:0]    res_o,
    output logic            carry_o,
    output logic            illegal_o
);
    op_class_e      cls;
    logic [W-1:0]   ar_res, lg_res;
    logic           ar_cout;
    logic           flag_upd;

    assign cls = classify(op_i);

    macro_alu_arith #(.W(W)) u_arith (
        .op(op_i), .a(a_i), .b(b_i), .cin(carry_o),
        .res(ar_res), .cout(ar_cout)
    );

    macro_alu_logic #(.W(W)) u_logic (
        .op(op_i), .a(a_i), .b(b_i), .res(lg_res)
    );

    always_comb begin
        case (cls)
            CLS_ARITH: res_o = ar_res;
            CLS_LOGIC: res_o = lg_res;
            default:   res_o = '0;
        endcase
        illegal_o = (cls == CLS_BAD);
        flag_upd  = flag_en_i && (cls == CLS_ARITH);
    end

    macro_alu_flag u_flag (
        .clk(clk), .rst(rst), .clr(clr_i),
        .upd(flag_upd), .nxt(ar_cout), .q(carry_o)
    );

    p_add_sum_r1: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_ADD) |-> (res_o == W'(a_i + b_i)));

    p_sub_noborrow_r3: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_SUB && flag_en_i && !clr_i) |=> (carry_o == ($past(a_i) >= $past(b_i))));

    p_logic_keeps_carry_r6: assert property (@(posedge clk) disable iff (rst)
        (op_i >= 4'd8 && op_i <= 4'd12 && !clr_i) |=> $stable(carry_o));

    p_illegal_zero_r9: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> (res_o == '0));
endmodule

// File: tb/macro_alu_tb.sv
`timescale 1ns/1ps
module macro_alu_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr_i = 1'b0;
    logic [3:0]  op_i = '0;
    logic [31:0] a_i = '0, b_i = '0;
    logic        flag_en_i = 1'b0;
    logic [31:0] res_o;
    logic        carry_o, illegal_o;

    int errors = 0;
    int checks = 0;
    bit mc = 1'b0;

    always #10 clk = ~clk;

    macro_alu u_dut (
        .clk(clk), .rst(rst), .clr_i(clr_i), .op_i(op_i), .a_i(a_i), .b_i(b_i),
        .flag_en_i(flag_en_i), .res_o(res_o), .carry_o(carry_o), .illegal_o(illegal_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                        input bit en, input bit clr);
        logic [31:0] er;
        bit ebad, nc, arith;
        string tag;
        longint unsigned ua, ub, uc;
        @(negedge clk);
        op_i = op; a_i = a; b_i = b; flag_en_i = en; clr_i = clr;
        ua = longint'(a); ub = longint'(b); uc = mc ? 1 : 0;
        er = '0; ebad = 0; nc = mc; arith = 0;
        case (op)
            4'd0: begin tag = "R1"; arith = 1; er = 32'(ua + ub); nc = (ua + ub) > 64'hFFFF_FFFF; end
            4'd1: begin tag = "R2"; arith = 1; er = 32'(ua + ub + uc); nc = (ua + ub + uc) > 64'hFFFF_FFFF; end
            4'd2: begin tag = "R3"; arith = 1; er = a - b; nc = (ua >= ub); end
            4'd3: begin tag = "R4"; arith = 1; er = a - b - 32'(1 - uc); nc = (ua >= ub + (1 - uc)); end
            4'd8:  begin tag = "R5"; er = a ^ b; end
            4'd9:  begin tag = "R5"; er = a | b; end
            4'd10: begin tag = "R5"; er = a & b; end
            4'd11: begin tag = "R5"; er = a & ~b; end
            4'd12: begin tag = "R5"; er = ~(a & b); end
            default: begin tag = "R9"; ebad = 1; end
        endcase
        #1;
        chk({tag, " result"}, res_o, er);
        chk("R9 illegal flag", {31'b0, illegal_o}, {31'b0, ebad});
        if (clr) mc = 0;
        else if (en && arith) mc = nc;
        @(negedge clk);
        if (clr) tag = "R8";
        else if (!en) tag = "R7";
        else if (ebad) tag = "R9";
        else if (!arith) tag = "R6";
        chk({tag, " carry"}, {31'b0, carry_o}, {31'b0, mc});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R10 reset carry", {31'b0, carry_o}, 32'd0);
        // directed corners
        step(4'd0, 32'hFFFF_FFFF, 32'h1, 1, 0);   // add overflow
        step(4'd1, 32'h0, 32'h0, 1, 0);           // adc uses carry 1
        step(4'd1, 32'hFFFF_FFFF, 32'h0, 1, 0);   // no carry in -> 0
        step(4'd2, 32'h5, 32'h5, 1, 0);           // equal -> no borrow
        step(4'd3, 32'h5, 32'h5, 1, 0);           // carry set -> A-B
        step(4'd2, 32'h0, 32'h1, 1, 0);           // borrow -> carry 0
        step(4'd3, 32'h5, 32'h5, 1, 0);           // carry clear -> A-B-1
        step(4'd3, 32'h0, 32'hFFFF_FFFF, 1, 0);
        step(4'd0, 32'h8000_0000, 32'h8000_0000, 1, 0);
        step(4'd8, 32'hF0F0_1234, 32'h0FF0_FFFF, 1, 0);
        step(4'd12, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 0);
        step(4'd11, 32'hDEAD_BEEF, 32'h0000_FFFF, 1, 0);
        step(4'd5, 32'h1234, 32'h5678, 1, 0);     // illegal, carry stays
        step(4'd15, 32'hFFFF_FFFF, 32'h1, 1, 0);
        step(4'd0, 32'h1, 32'h1, 0, 0);           // enable low
        step(4'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 1); // clear wins
        step(4'd2, 32'h9, 32'h3, 0, 0);
        for (int i = 0; i < 400; i++) begin
            logic [3:0] op;
            logic [31:0] a, b;
            int sel;
            sel = $urandom_range(0, 15);
            op = 4'(sel);
            a = $urandom;
            b = $urandom;
            if ($urandom_range(0, 3) == 0) b = a;
            if ($urandom_range(0, 5) == 0) a = 32'hFFFF_FFFF;
            step(op, a, b, $urandom_range(0, 3) != 0, $urandom_range(0, 9) == 0);
        end
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule